// File: doc/BRIEF.md
# Vector-Loop Issue Sequencer

This block turns one decoded scalar operation into a run of scalar element operations. Each register carries a one-bit vector tag. When an operand's base register is tagged, its register number steps up by one for each element. When it is untagged, the same register is used for every element, so the operand acts as a scalar broadcast. An optional predicate word gates each element. Element i is sent only when bit i of the predicate is set. There is no separate vector opcode: the tags alone make an operation a vector.

When the fetch and decode side offers an operation, the sequencer captures it and raises a program-counter hold, so that no further instruction is fetched. It then walks the element index from 0 up to the vector length minus one. Each active element is presented to the execution pipeline as one scalar micro-operation over a valid/ready handshake. A masked element is stepped over in a single cycle without issuing. When the walk is complete, a one-cycle done pulse is raised and the hold is released.

Top module: `vloop_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `pc_hold`, `uop_valid` and `done` are all low.
- R2: A `start` seen while `pc_hold` is low is accepted at that clock edge, and `pc_hold` is high from the next cycle until the cycle after `done`.
- R3: Issued micro-operations carry element indices in strictly ascending order, within 0 to VL-1, on `uop_idx`.
- R4: An operand whose base register is vector-tagged (`vec_tag[base]`=1) is issued as register (base + index) modulo 32, so register numbers wrap from 31 to 0.
- R5: An operand whose base register is untagged is issued with its base register number for every element.
- R6: With `pred_on`=1, element i is issued only if `pred_bits[i]`=1. A masked element issues nothing and takes exactly one cycle.
- R7: With `pred_on`=0, every element from 0 to VL-1 is issued, whatever `pred_bits` holds.
- R8: While `uop_valid` is high and `uop_ready` is low, the presented micro-operation (index and all three register numbers) holds and `uop_valid` stays high.
- R9: `done` is high for exactly one cycle. With `uop_ready` held high, it comes in cycle VL+1 after the accepting edge, and `pc_hold` is low in the cycle after `done`.
- R10: With VL=0, or with every element masked, nothing is issued. For VL=0, `done` comes in the first cycle after the accepting edge.
- R11: A `start` asserted while `pc_hold` is high is ignored: the operation in progress keeps its own operands and length.
- R12: A requested length above 16 (the maximum) is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Offer of a decoded operation |
| op_rd | input | 5 | Destination base register |
| op_rs1 | input | 5 | First source base register |
| op_rs2 | input | 5 | Second source base register |
| op_vl | input | 5 | Requested vector length |
| pred_on | input | 1 | Predicate applies to this operation |
| pred_bits | input | 16 | Predicate register contents, bit i for element i |
| vec_tag | input | 32 | Vector tag per register number |
| pc_hold | output | 1 | Holds the program counter while the loop runs |
| uop_valid | output | 1 | Micro-operation presented |
| uop_ready | input | 1 | Pipeline accepts the micro-operation |
| uop_idx | output | 5 | Element index of the presented micro-operation |
| uop_rd | output | 5 | Issued destination register |
| uop_rs1 | output | 5 | Issued first source register |
| uop_rs2 | output | 5 | Issued second source register |
| done | output | 1 | One-cycle pulse at loop end |

## Verification
A corrupted element index shows up as a wrong register number on the very next issued micro-operation, or as a skipped or repeated element. It can also move the done pulse by a cycle, because with ready held high the loop takes exactly VL+1 cycles whether elements are masked or not. A wrong loop state shows within one cycle as `pc_hold` staying high after `done` or dropping too early. A latch that recaptures operands shows on the first element after a mid-loop `start`. Stall handling is judged cycle by cycle, comparing each presented micro-operation with the one before while ready was low.

// File: rtl/vloop_pkg.sv
`timescale 1ns/1ps
package vloop_pkg;
    parameter int NREG  = 32;
    parameter int MAXVL = 16;
    localparam int REGW = $clog2(NREG);
    localparam int VLW  = $clog2(MAXVL + 1);
    localparam int ELW  = $clog2(MAXVL);
    localparam int NOPS = 3;

    typedef logic [REGW-1:0] regnum_t;
    typedef logic [VLW-1:0]  vlen_t;

    typedef struct packed {
        regnum_t base;
        logic    vec;
    } opnd_t;

    typedef struct packed {
        opnd_t              dst;
        opnd_t              src1;
        opnd_t              src2;
        vlen_t              len;
        logic               masked;
        logic [MAXVL-1:0]   mask;
    } instr_t;

    typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} state_t;

    function automatic regnum_t step_reg(opnd_t o, vlen_t idx);
        return o.vec ? regnum_t'(o.base + regnum_t'(idx)) : o.base;
    endfunction

    function automatic vlen_t clamp_len(vlen_t v);
        return (v > vlen_t'(MAXVL)) ? vlen_t'(MAXVL) : v;
    endfunction
endpackage

// File: rtl/vloop_latch.sv
`timescale 1ns/1ps
module vloop_latch
    import vloop_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  regnum_t             rd_in,
    input  regnum_t             rs1_in,
    input  regnum_t             rs2_in,
    input  vlen_t               len_in,
    input  logic                masked_in,
    input  logic [MAXVL-1:0]    mask_in,
    input  logic [NREG-1:0]     tags,
    output instr_t              held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (accept) begin
            held.dst    <= '{base: rd_in,  vec: tags[rd_in]};
            held.src1   <= '{base: rs1_in, vec: tags[rs1_in]};
            held.src2   <= '{base: rs2_in, vec: tags[rs2_in]};
            held.len    <= clamp_len(len_in);
            held.masked <= masked_in;
            held.mask   <= mask_in;
        end
    end
endmodule

// File: rtl/vloop_mask.sv
`timescale 1ns/1ps
module vloop_mask
    import vloop_pkg::*;
(
    input  logic                masked,
    input  logic [MAXVL-1:0]    mask,
    input  vlen_t               idx,
    output logic                active
);
    always_comb begin
        active = !masked || mask[idx[ELW-1:0]];
    end
endmodule

// File: rtl/vloop_regstep.sv
`timescale 1ns/1ps
module vloop_regstep
    import vloop_pkg::*;
(
    input  opnd_t   opnd,
    input  vlen_t   idx,
    output regnum_t regnum
);
    always_comb begin
        regnum = step_reg(opnd, idx);
    end
endmodule

// File: rtl/vloop_ctrl.sv
`timescale 1ns/1ps
module vloop_ctrl
    import vloop_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    active,
    input  logic    ready,
    input  vlen_t   len,
    output logic    accept,
    output logic    busy,
    output logic    valid,
    output logic    fin,
    output vlen_t   idx
);
    state_t state;
    logic   running;
    logic   at_end;
    logic   advance;

    always_comb begin
        running = (state == S_RUN);
        at_end  = running && (idx == len);
        accept  = start && !running;
        valid   = running && !at_end && active;
        advance = running && !at_end && (!active || ready);
        fin     = at_end;
        busy    = running;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            idx   <= '0;
        end else if (accept) begin
            state <= S_RUN;
            idx   <= '0;
        end else if (at_end) begin
            state <= S_IDLE;
        end else if (advance) begin
            idx <= idx + vlen_t'(1);
        end
    end
endmodule

// File: rtl/vloop_top.sv
`timescale 1ns/1ps
module vloop_top
    import vloop_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [REGW-1:0]     op_rd,
    input  logic [REGW-1:0]     op_rs1,
    input  logic [REGW-1:0]     op_rs2,
    input  logic [VLW-1:0]      op_vl,
    input  logic                pred_on,
    input  logic [MAXVL-1:0]    pred_bits,
    input  logic [NREG-1:0]     vec_tag,
    output logic                pc_hold,
    output logic                uop_valid,
    input  logic                uop_ready,
    output logic [VLW-1:0]      uop_idx,
    output logic [REGW-1:0]     uop_rd,
    output logic [REGW-1:0]     uop_rs1,
    output logic [REGW-1:0]     uop_rs2,
    output logic                done
);
    instr_t  held;
    logic    accept;
    logic    active;
    vlen_t   idx;
    opnd_t   opnds [NOPS];
    regnum_t regs  [NOPS];

    vloop_latch u_latch (
        .clk(clk), .rst(rst), .accept(accept),
        .rd_in(op_rd), .rs1_in(op_rs1), .rs2_in(op_rs2),
        .len_in(op_vl), .masked_in(pred_on), .mask_in(pred_bits),
        .tags(vec_tag), .held(held)
    );

    vloop_mask u_mask (
        .masked(held.masked), .mask(held.mask), .idx(idx), .active(active)
    );

    vloop_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .active(active),
        .ready(uop_ready), .len(held.len), .accept(accept),
        .busy(pc_hold), .valid(uop_valid), .fin(done), .idx(idx)
    );

    always_comb begin
        opnds[0] = held.dst;
        opnds[1] = held.src1;
        opnds[2] = held.src2;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_step
        vloop_regstep u_step (.opnd(opnds[g]), .idx(idx), .regnum(regs[g]));
    end

    assign uop_idx = idx;
    assign uop_rd  = regs[0];
    assign uop_rs1 = regs[1];
    assign uop_rs2 = regs[2];
endmodule

// File: rtl/vloop_check.sv
`timescale 1ns/1ps
module vloop_check
    import vloop_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             pc_hold,
    input logic             uop_valid,
    input logic             uop_ready,
    input logic [VLW-1:0]   uop_idx,
    input logic [REGW-1:0]  uop_rd,
    input logic [REGW-1:0]  uop_rs1,
    input logic [REGW-1:0]  uop_rs2,
    input logic             done
);
    assert_enter_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !pc_hold) |=> pc_hold);

    assert_issue_inside_R2: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> (pc_hold && !done));

    assert_index_step_R3: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_ready) |=> (uop_idx == VLW'($past(uop_idx) + 1)));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_idx) &&
            $stable(uop_rd) && $stable(uop_rs1) && $stable(uop_rs2)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_release_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !pc_hold);
endmodule

bind vloop_top vloop_check u_check (
    .clk(clk), .rst(rst), .start(start), .pc_hold(pc_hold),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_idx(uop_idx),
    .uop_rd(uop_rd), .uop_rs1(uop_rs1), .uop_rs2(uop_rs2), .done(done)
);

// File: tb/tb_vloop_top.sv
`timescale 1ns/1ps
module tb_vloop_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [4:0]  op_rd, op_rs1, op_rs2, op_vl;
    logic        pred_on;
    logic [15:0] pred_bits;
    logic [31:0] vec_tag;
    logic        pc_hold, uop_valid, uop_ready, done;
    logic [4:0]  uop_idx, uop_rd, uop_rs1, uop_rs2;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vloop_top dut (
        .clk(clk), .rst(rst), .start(start),
        .op_rd(op_rd), .op_rs1(op_rs1), .op_rs2(op_rs2), .op_vl(op_vl),
        .pred_on(pred_on), .pred_bits(pred_bits), .vec_tag(vec_tag),
        .pc_hold(pc_hold), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_idx(uop_idx), .uop_rd(uop_rd), .uop_rs1(uop_rs1),
        .uop_rs2(uop_rs2), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_reg(int base, logic [31:0] tags, int i);
        return tags[base] ? (base + i) % 32 : base;
    endfunction

    // Runs one operation and checks the issued stream against the model.
    task automatic do_run(input int rd, input int rs1, input int rs2,
                          input logic [31:0] tags, input int vl,
                          input bit pon, input logic [15:0] pbits,
                          input bit stall, input bit poke, input string req);
        int evl, nexp, n, dk;
        int elist [16];
        bit prev_stall;
        int p_idx, p_rd, p_rs1, p_rs2;
        evl  = (vl > 16) ? 16 : vl;
        nexp = 0;
        for (int i = 0; i < evl; i++)
            if (!pon || pbits[i]) begin elist[nexp] = i; nexp++; end
        @(negedge clk);
        op_rd = 5'(rd); op_rs1 = 5'(rs1); op_rs2 = 5'(rs2); op_vl = 5'(vl);
        pred_on = pon; pred_bits = pbits; vec_tag = tags;
        uop_ready = 1'b1; start = 1'b1;
        n = 0; dk = -1; prev_stall = 0;
        p_idx = 0; p_rd = 0; p_rs1 = 0; p_rs2 = 0;
        for (int k = 1; k < 200; k++) begin
            @(negedge clk);
            start = 1'b0;
            uop_ready = stall ? ((k % 3) != 2) : 1'b1;
            if (poke && k == 2) begin
                start = 1'b1; op_rd = 5'd7; op_rs1 = 5'd8; op_rs2 = 5'd9;
                op_vl = 5'd2; pred_on = 1'b0; vec_tag = '0;
            end
            #1;
            if (k == 1) chk(pc_hold == 1'b1, "R2", "pc_hold after accept", pc_hold, 1);
            if (prev_stall)
                chk(uop_valid && uop_idx == p_idx && uop_rd == p_rd &&
                    uop_rs1 == p_rs1 && uop_rs2 == p_rs2, "R8",
                    "stalled uop held (idx)", uop_idx, p_idx);
            prev_stall = uop_valid && !uop_ready;
            p_idx = uop_idx; p_rd = uop_rd; p_rs1 = uop_rs1; p_rs2 = uop_rs2;
            if (uop_valid && uop_ready) begin
                if (n < nexp) begin
                    chk(uop_idx == elist[n], req, "element index", uop_idx, elist[n]);
                    chk(uop_rd == exp_reg(rd, tags, elist[n]), req, "rd", uop_rd,
                        exp_reg(rd, tags, elist[n]));
                    chk(uop_rs1 == exp_reg(rs1, tags, elist[n]), req, "rs1", uop_rs1,
                        exp_reg(rs1, tags, elist[n]));
                    chk(uop_rs2 == exp_reg(rs2, tags, elist[n]), req, "rs2", uop_rs2,
                        exp_reg(rs2, tags, elist[n]));
                end
                n++;
            end
            if (done) begin dk = k; break; end
        end
        start = 1'b0;
        chk(n == nexp, req, "issued count", n, nexp);
        if (!stall) chk(dk == evl + 1, "R9", "done cycle", dk, evl + 1);
        else        chk(dk > evl, "R9", "done seen", dk, evl + 1);
        @(negedge clk); #1;
        chk(pc_hold == 1'b0, "R9", "pc_hold after done", pc_hold, 0);
        chk(done == 1'b0, "R9", "done single cycle", done, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; uop_ready = 1'b1;
        op_rd = '0; op_rs1 = '0; op_rs2 = '0; op_vl = '0;
        pred_on = 1'b0; pred_bits = '0; vec_tag = '0;
        repeat (3) @(negedge clk);
        chk(!pc_hold && !uop_valid && !done, "R1", "outputs in reset",
            {pc_hold, uop_valid, done}, 0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(!pc_hold && !uop_valid && !done, "R1", "outputs after reset",
            {pc_hold, uop_valid, done}, 0);
    endtask

    task automatic t_all_vector;   // R3 R4
        do_run(4, 10, 20, 32'h0010_0410, 4, 0, '0, 0, 0, "R3");
    endtask
    task automatic t_broadcast;    // R5: rs2 untagged
        do_run(2, 6, 12, 32'h0000_0044, 5, 0, '0, 0, 0, "R5");
    endtask
    task automatic t_wrap;         // R4: 30,31,0,1,2
        do_run(30, 1, 3, 32'h4000_0000, 5, 0, '0, 0, 0, "R4");
    endtask
    task automatic t_predicate;    // R6
        do_run(8, 16, 24, 32'h0101_0100, 8, 1, 16'b1011_0110, 0, 0, "R6");
    endtask
    task automatic t_no_pred;      // R7
        do_run(3, 5, 7, 32'h0000_00a8, 6, 0, 16'h0000, 0, 0, "R7");
    endtask
    task automatic t_stall;        // R8
        do_run(0, 9, 18, 32'h0004_0201, 7, 1, 16'b0101_1011, 1, 0, "R8");
    endtask
    task automatic t_zero_len;     // R10
        do_run(1, 2, 3, 32'hffff_ffff, 0, 0, '0, 0, 0, "R10");
    endtask
    task automatic t_all_masked;   // R10
        do_run(1, 2, 3, 32'hffff_ffff, 6, 1, 16'hffc0, 0, 0, "R10");
    endtask
    task automatic t_clamp;        // R12
        do_run(0, 16, 5, 32'h0001_0001, 20, 0, '0, 0, 0, "R12");
    endtask
    task automatic t_busy_start;   // R11
        do_run(11, 12, 13, 32'h0000_3800, 5, 0, '0, 0, 1, "R11");
    endtask

    initial begin
        t_reset();
        t_all_vector();
        t_broadcast();
        t_wrap();
        t_predicate();
        t_no_pred();
        t_stall();
        t_zero_len();
        t_all_masked();
        t_clamp();
        t_busy_start();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule